// File: doc/BRIEF.md
# Layered Offset Min-Sum Row Processor

This block is one processing unit of a row-layered decoder for a regular low-density parity-check code with check degree 6 and variable degree 3. Each issue carries one parity-check row: for every one of the row's six edges it brings the variable's running total belief and the check-to-variable message last stored for that edge. The block returns an updated total and an updated message for every edge.

For each edge, the first pipeline stage subtracts the old message from the total to form the variable-to-check message, saturated to the message range. The second stage runs the offset min-sum check update on all six edges in parallel. It then adds each new message back onto its variable-to-check message to give the new total, which is saturated to the total width. A valid flag and a row tag travel with the data. A new row may be issued on every clock, and the results of each row appear two clocks after it is issued. The external memory, the choice of row address and the stopping decision belong to the surrounding decoder.

Top module: `lms_row_unit`

## Requirements
- R1: While reset is asserted and after it is released with no issue, `out_valid_o` is 0 and the total, message and tag outputs are all zero.
- R2: A row presented with `in_valid_i` high at a clock edge appears with `out_valid_o` high after exactly two further rising edges, carrying its `in_tag_i`. Rows may be issued on consecutive clocks, and they emerge in issue order with no loss.
- R3: The variable-to-check message of edge e is the total of edge e minus the old message of edge e, clamped to [-(2^(MSG_W-1)-1), +(2^(MSG_W-1)-1)], which is [-31, 31] for 6 bits.
- R4: The new message magnitude of edge e is max(m - OFFSET, 0), where m is the smallest variable-to-check magnitude among the other edges of the row. OFFSET defaults to 1.
- R5: The new message of edge e is negative exactly when an odd number of the other edges carry negative variable-to-check messages. Zero counts as non-negative, and a zero magnitude is always output as 0.
- R6: When several edges share the smallest magnitude, each of them receives that smallest magnitude minus the offset, and the first of them in edge order is taken as the minimum position.
- R7: The new total of edge e is its variable-to-check message plus its new message, clamped to [-(2^(TOT_W-1)-1), +(2^(TOT_W-1)-1)].
- R8: No output message ever takes the value -2^(MSG_W-1).
- R9: In a cycle with no valid result, the total, message and tag outputs keep the values of the last valid result.
- R10: Edge e occupies bits [e*TOT_W +: TOT_W] of the total buses and [e*MSG_W +: MSG_W] of the message buses, in two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Row issue strobe |
| in_tag_i | input | TAG_W | Row tag carried with the row |
| in_tot_i | input | DEG*TOT_W | Total beliefs of the row's variables |
| in_msg_i | input | DEG*MSG_W | Stored check-to-variable messages of the row |
| out_valid_o | output | 1 | Result strobe |
| out_tag_o | output | TAG_W | Tag of the returned row |
| out_tot_o | output | DEG*TOT_W | Updated total beliefs |
| out_msg_o | output | DEG*MSG_W | Updated check-to-variable messages |

## Verification
The bench builds the unit with DEG=6, MSG_W=6, OFFSET=1, a narrow TOT_W of 6 and a 4-bit tag. The narrow total width lets ordinary message sums reach the total clamp in both directions, and it lets differences of inputs reach the message clamp. Directed rows cover ties, zero-magnitude floors and both clamps. Several hundred pseudo-random rows, first issued back to back and then with gaps, exercise the sign parity, the second-minimum selection, the issue order and the two-cycle latency. Each result is compared with a model that searches the other five edges directly.

// File: rtl/lms_row_pkg.sv
package lms_row_pkg;
  function automatic int sat_sym(input int v, input int lim);
    if (v > lim) return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction
endpackage

// File: rtl/lms_v2c.sv
module lms_v2c #(
  parameter int TOT_W = 8,
  parameter int MSG_W = 6
) (
  input  logic signed [TOT_W-1:0] tot_i,
  input  logic signed [MSG_W-1:0] lam_i,
  output logic signed [MSG_W-1:0] v2c_o
);
  localparam int MSG_MAX = 2 ** (MSG_W - 1) - 1;
  int diff;
  always_comb begin
    diff  = int'(tot_i) - int'(lam_i);
    v2c_o = MSG_W'(lms_row_pkg::sat_sym(diff, MSG_MAX));
  end
endmodule

// File: rtl/lms_cnp.sv
module lms_cnp #(
  parameter int DEG    = 6,
  parameter int MSG_W  = 6,
  parameter int OFFSET = 1
) (
  input  logic [DEG*MSG_W-1:0] v2c_i,
  output logic [DEG*MSG_W-1:0] c2v_o
);
  localparam int IDX_W = (DEG > 1) ? $clog2(DEG) : 1;
  localparam int BIG   = 2 ** MSG_W;

  int              mag [DEG];
  logic            sgn [DEG];
  int              min1, min2;
  logic [IDX_W-1:0] min_idx;
  logic            par;

  always_comb begin
    min1    = BIG;
    min2    = BIG;
    min_idx = '0;
    par     = 1'b0;
    for (int e = 0; e < DEG; e++) begin
      sgn[e] = v2c_i[e*MSG_W + MSG_W - 1];
      mag[e] = sgn[e] ? -int'(signed'(v2c_i[e*MSG_W +: MSG_W]))
                      :  int'(signed'(v2c_i[e*MSG_W +: MSG_W]));
      par    = par ^ sgn[e];
      // strict compare keeps the first index on ties
      if (mag[e] < min1) begin
        min2    = min1;
        min1    = mag[e];
        min_idx = IDX_W'(e);
      end else if (mag[e] < min2) begin
        min2 = mag[e];
      end
    end
  end

  for (genvar g = 0; g < DEG; g++) begin : g_out
    int   m, om;
    logic os;
    always_comb begin
      m  = (int'(min_idx) == g) ? min2 : min1;
      om = (m > OFFSET) ? m - OFFSET : 0;
      os = par ^ sgn[g];
      c2v_o[g*MSG_W +: MSG_W] = (os && om != 0) ? MSG_W'(-om) : MSG_W'(om);
    end
  end
endmodule

// File: rtl/lms_vsum.sv
module lms_vsum #(
  parameter int TOT_W = 8,
  parameter int MSG_W = 6
) (
  input  logic signed [MSG_W-1:0] v2c_i,
  input  logic signed [MSG_W-1:0] c2v_i,
  output logic signed [TOT_W-1:0] tot_o
);
  localparam int TOT_MAX = 2 ** (TOT_W - 1) - 1;
  int s;
  always_comb begin
    s     = int'(v2c_i) + int'(c2v_i);
    tot_o = TOT_W'(lms_row_pkg::sat_sym(s, TOT_MAX));
  end
endmodule

// File: rtl/lms_row_unit.sv
module lms_row_unit #(
  parameter int DEG    = 6,
  parameter int MSG_W  = 6,
  parameter int TOT_W  = 8,
  parameter int TAG_W  = 8,
  parameter int OFFSET = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  input  logic [TAG_W-1:0]     in_tag_i,
  input  logic [DEG*TOT_W-1:0] in_tot_i,
  input  logic [DEG*MSG_W-1:0] in_msg_i,
  output logic                 out_valid_o,
  output logic [TAG_W-1:0]     out_tag_o,
  output logic [DEG*TOT_W-1:0] out_tot_o,
  output logic [DEG*MSG_W-1:0] out_msg_o
);
  logic [DEG*MSG_W-1:0] v2c_d, s1_v2c, c2v_d;
  logic [DEG*TOT_W-1:0] tot_d;
  logic                 s1_valid;
  logic [TAG_W-1:0]     s1_tag;

  for (genvar g = 0; g < DEG; g++) begin : g_vnp
    lms_v2c #(.TOT_W(TOT_W), .MSG_W(MSG_W)) u_sub (
      .tot_i (in_tot_i[g*TOT_W +: TOT_W]),
      .lam_i (in_msg_i[g*MSG_W +: MSG_W]),
      .v2c_o (v2c_d[g*MSG_W +: MSG_W])
    );
    lms_vsum #(.TOT_W(TOT_W), .MSG_W(MSG_W)) u_add (
      .v2c_i (s1_v2c[g*MSG_W +: MSG_W]),
      .c2v_i (c2v_d[g*MSG_W +: MSG_W]),
      .tot_o (tot_d[g*TOT_W +: TOT_W])
    );
  end

  lms_cnp #(.DEG(DEG), .MSG_W(MSG_W), .OFFSET(OFFSET)) u_cnp (
    .v2c_i (s1_v2c),
    .c2v_o (c2v_d)
  );

  // stage 1: variable-to-check messages
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_tag   <= '0;
      s1_v2c   <= '0;
    end else begin
      s1_valid <= in_valid_i;
      if (in_valid_i) begin
        s1_tag <= in_tag_i;
        s1_v2c <= v2c_d;
      end
    end
  end

  // stage 2: check update and new totals
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_tag_o   <= '0;
      out_tot_o   <= '0;
      out_msg_o   <= '0;
    end else begin
      out_valid_o <= s1_valid;
      if (s1_valid) begin
        out_tag_o <= s1_tag;
        out_tot_o <= tot_d;
        out_msg_o <= c2v_d;
      end
    end
  end
endmodule

// File: rtl/lms_row_unit_chk.sv
module lms_row_unit_chk #(
  parameter int DEG    = 6,
  parameter int MSG_W  = 6,
  parameter int TOT_W  = 8,
  parameter int TAG_W  = 8,
  parameter int OFFSET = 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 in_valid_i,
  input logic [TAG_W-1:0]     in_tag_i,
  input logic [DEG*TOT_W-1:0] in_tot_i,
  input logic [DEG*MSG_W-1:0] in_msg_i,
  input logic                 out_valid_o,
  input logic [TAG_W-1:0]     out_tag_o,
  input logic [DEG*TOT_W-1:0] out_tot_o,
  input logic [DEG*MSG_W-1:0] out_msg_o
);
  logic [1:0] since_rst;
  logic       bad_msg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  always_comb begin
    bad_msg = 1'b0;
    for (int e = 0; e < DEG; e++)
      if (out_msg_o[e*MSG_W +: MSG_W] == {1'b1, {(MSG_W-1){1'b0}}}) bad_msg = 1'b1;
  end

  a_r2_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 2'd2) |-> (out_valid_o == $past(in_valid_i, 2)));

  a_r2_tag_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 2'd2 && out_valid_o) |-> (out_tag_o == $past(in_tag_i, 2)));

  a_r8_msg_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bad_msg);

  a_r9_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 2'd1 && !out_valid_o) |->
      ($stable(out_msg_o) && $stable(out_tot_o) && $stable(out_tag_o)));
endmodule

bind lms_row_unit lms_row_unit_chk #(
  .DEG(DEG), .MSG_W(MSG_W), .TOT_W(TOT_W), .TAG_W(TAG_W), .OFFSET(OFFSET)
) u_chk (.*);

// File: tb/lms_row_unit_test.sv
module lms_row_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEG = 6, MSG_W = 6, TOT_W = 6, TAG_W = 4, OFS = 1;
  localparam int MSG_MAX = 31, TOT_MAX = 31;
  localparam int QN = 1024;

  logic                 clk_i = 1'b0, rst_ni = 1'b0, in_valid_i = 1'b0;
  logic [TAG_W-1:0]     in_tag_i = '0;
  logic [DEG*TOT_W-1:0] in_tot_i = '0;
  logic [DEG*MSG_W-1:0] in_msg_i = '0;
  logic                 out_valid_o;
  logic [TAG_W-1:0]     out_tag_o;
  logic [DEG*TOT_W-1:0] out_tot_o;
  logic [DEG*MSG_W-1:0] out_msg_o;

  lms_row_unit #(.DEG(DEG), .MSG_W(MSG_W), .TOT_W(TOT_W), .TAG_W(TAG_W), .OFFSET(OFS)) uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, cyc = 0, wr = 0, rd = 0;
  logic [DEG*MSG_W-1:0] q_msg [QN];
  logic [DEG*TOT_W-1:0] q_tot [QN];
  logic [TAG_W-1:0]     q_tag [QN];
  int                   q_cyc [QN];
  string                q_lbl [QN];
  int unsigned          seed = 32'h1234_5678;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int sat(input int v, input int lim);
    return (v > lim) ? lim : (v < -lim) ? -lim : v;
  endfunction

  task automatic issue(input int t[DEG], input int m[DEG], input string lbl);
    int v[DEG];
    for (int e = 0; e < DEG; e++) v[e] = sat(t[e] - m[e], MSG_MAX);  // R3
    for (int e = 0; e < DEG; e++) begin
      int mn = 1000, mg, c; bit sg = 0;
      for (int k = 0; k < DEG; k++)
        if (k != e) begin
          int a = (v[k] < 0) ? -v[k] : v[k];
          if (a < mn) mn = a;
          sg ^= (v[k] < 0);
        end
      mg = (mn > OFS) ? mn - OFS : 0;          // R4
      c  = (sg && mg != 0) ? -mg : mg;         // R5
      q_msg[wr % QN][e*MSG_W +: MSG_W] = MSG_W'(c);
      q_tot[wr % QN][e*TOT_W +: TOT_W] = TOT_W'(sat(v[e] + c, TOT_MAX));  // R7
      in_tot_i[e*TOT_W +: TOT_W] = TOT_W'(t[e]);
      in_msg_i[e*MSG_W +: MSG_W] = MSG_W'(m[e]);
    end
    in_tag_i = TAG_W'(wr);
    q_tag[wr % QN] = TAG_W'(wr);
    q_cyc[wr % QN] = cyc;
    q_lbl[wr % QN] = lbl;
    wr++;
    in_valid_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  function automatic int rnd(input int lo, input int hi);
    seed = seed * 32'd1664525 + 32'd1013904223;
    return lo + int'((seed >> 8) % (hi - lo + 1));
  endfunction

  always @(negedge clk_i) begin
    if (rst_ni && out_valid_o) begin
      if (rd >= wr) begin
        check(0, "R2", "unexpected result", 64'(out_tag_o), 64'(0));
      end else begin
        check(cyc == q_cyc[rd % QN] + 2, "R2", "latency", 64'(cyc), 64'(q_cyc[rd % QN] + 2));
        check(out_tag_o == q_tag[rd % QN], "R2", "tag", 64'(out_tag_o), 64'(q_tag[rd % QN]));
        check(out_msg_o == q_msg[rd % QN], q_lbl[rd % QN], "messages (R10 packing)",
              64'(out_msg_o), 64'(q_msg[rd % QN]));
        check(out_tot_o == q_tot[rd % QN], "R7", "totals", 64'(out_tot_o), 64'(q_tot[rd % QN]));
        rd++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    check(0, "watchdog", "timeout", 64'(cyc), 64'(0));
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [DEG*MSG_W-1:0] h_msg;
    logic [DEG*TOT_W-1:0] h_tot;
    logic [TAG_W-1:0]     h_tag;
    int z[DEG] = '{0, 0, 0, 0, 0, 0};
    repeat (3) @(negedge clk_i);
    check(out_valid_o == 0 && out_msg_o == 0 && out_tot_o == 0 && out_tag_o == 0,
          "R1", "reset state", 64'(out_msg_o), 64'(0));
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(out_valid_o == 0 && out_msg_o == 0 && out_tot_o == 0,
          "R1", "idle after reset", 64'(out_valid_o), 64'(0));

    issue('{10, -5, 20, 3, -8, 15}, z, "R4 R5");
    issue('{4, -4, 7, 9, 4, 12}, z, "R6");
    issue('{31, -32, 5, -6, 7, 8}, '{-32, 31, 0, 0, 0, 0}, "R3");
    issue('{1, 0, -1, 20, 20, 20}, z, "R4 R5");
    issue('{31, 31, 31, 31, 31, 31}, z, "R7");
    issue('{-31, -31, -31, -31, -31, -31}, z, "R7");
    issue('{0, 0, 0, 0, 0, 0}, '{-32, -32, -32, 5, 5, 5}, "R3");
    repeat (3) @(negedge clk_i);

    for (int r = 0; r < 400; r++) begin
      int t[DEG], m[DEG];
      for (int e = 0; e < DEG; e++) begin t[e] = rnd(-32, 31); m[e] = rnd(-32, 31); end
      issue(t, m, "R4 R5");
    end
    for (int r = 0; r < 100; r++) begin
      int t[DEG], m[DEG];
      for (int e = 0; e < DEG; e++) begin t[e] = rnd(-12, 12); m[e] = rnd(-6, 6); end
      issue(t, m, "R4 R5 R6");
      repeat (rnd(0, 2)) @(negedge clk_i);
    end

    repeat (3) @(negedge clk_i);
    h_msg = out_msg_o; h_tot = out_tot_o; h_tag = out_tag_o;
    repeat (4) @(negedge clk_i);
    check(out_valid_o == 0, "R9", "valid low when idle", 64'(out_valid_o), 64'(0));
    check(out_msg_o == h_msg && out_tot_o == h_tot && out_tag_o == h_tag,
          "R9", "outputs held", 64'(out_msg_o), 64'(h_msg));
    check(rd == wr, "R2", "all rows returned", 64'(rd), 64'(wr));
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule